// File: doc/BRIEF.md
# Remote Input Read Bridge

This block lets a local requester read an input event that lives on a remote satellite across a packet link. The requester chooses a channel and a timeout timestamp, then pulses a one-cycle read command. The bridge captures both values and offers one read request to the link transmitter over a valid/ready handshake. It then waits for the matching reply from the link receiver.

While the transaction is open, the bridge shows a pending bit in its input status word. When the reply arrives, the bridge turns it into one of three results. An event reply loads the returned timestamp and data word into the result outputs. A no-event reply reports either a timeout or an overflow, depending on the one flag it carries.

A routing lookup outside the block says whether the selected channel's destination can be reached. If it cannot, the bridge reports this at once and sends nothing. Reads are serviced strictly one at a time: a new command is refused until the open transaction completes.

Top module: `remote_read_bridge`

## Requirements
- R1: After reset, `in_status` is 0, `req_valid` is 0, and `in_timestamp` and `in_data` are 0.
- R2: A `cmd_read` pulse while status bit 2 (pending) is clear and `chan_unreachable` is low is accepted. One cycle later, bit 2 is set, `req_valid` is high, and `req_chan`/`req_timeout` equal the values presented with the command. Bits 0, 1 and 3 and both result outputs read 0 at that point.
- R3: `req_valid` stays high with `req_chan` and `req_timeout` unchanged until a cycle in which `req_ready` is high. Exactly one request handshake happens per accepted command.
- R4: A reply with `rep_valid` high and `rep_type` = 1 (event), received after the request handshake, has the following effect one cycle later: `in_timestamp` and `in_data` hold the reply's timestamp and data, and `in_status` is 0.
- R5: A reply with `rep_type` = 2 (no event) and `rep_overflow` = 0 leaves `in_status` = 0x1 (timeout only) one cycle later.
- R6: A reply with `rep_type` = 2 and `rep_overflow` = 1 leaves `in_status` = 0x2 (overflow only) one cycle later.
- R7: A `cmd_read` while no read is pending and `chan_unreachable` is high gives `in_status` = 0x8 one cycle later. No request is issued, the pending bit stays clear, and the result outputs read 0.
- R8: A `cmd_read` while bit 2 is set is ignored. No extra request is issued, `req_chan`/`req_timeout` keep their values, and bit 2 stays set until the reply arrives.
- R9: A reply is ignored if it arrives before the request handshake, or carries a type code other than 1 or 2. In that case bit 2 stays set and the result outputs are unchanged.
- R10: Result outputs and error bits hold their values after completion until the next `cmd_read` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_read | input | 1 | One-cycle read command pulse |
| cmd_chan | input | 24 | Channel to read |
| cmd_timeout | input | 64 | Timeout timestamp for the read |
| chan_unreachable | input | 1 | Routing lookup: destination of `cmd_chan` is unreachable |
| req_valid | output | 1 | Read request offered to the link |
| req_ready | input | 1 | Link accepts the request |
| req_chan | output | 24 | Channel field of the request |
| req_timeout | output | 64 | Timeout field of the request |
| rep_valid | input | 1 | One-cycle reply strobe |
| rep_type | input | 2 | Reply type: 1 event, 2 no event |
| rep_overflow | input | 1 | No-event flag: 1 overflow, 0 timeout |
| rep_timestamp | input | 64 | Event timestamp of the reply |
| rep_data | input | 32 | Event data of the reply |
| in_status | output | 4 | {unreachable, pending, overflow, timeout} |
| in_timestamp | output | 64 | Last event timestamp |
| in_data | output | 32 | Last event data |

## Verification
Every result is due exactly one clock edge after its cause. The pending bit and request are due one edge after the command. The request leaves one edge after `req_ready` is seen high. The status and result outputs are due one edge after the reply strobe, and the unreachable bit one edge after the command. The bench drives each stimulus at a falling edge, clears it at the next falling edge, and samples the outputs at that second falling edge, after exactly one rising edge. It also counts request handshakes at each rising edge, which shows that exactly one request was made per accepted command.

// File: rtl/rrb_pkg.sv
// Package: shared state type, reply type codes and status bit positions
// for the remote input read bridge.
package rrb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } rrb_state_e;

    localparam logic [1:0] REP_EVENT   = 2'd1;
    localparam logic [1:0] REP_NOEVENT = 2'd2;

    localparam int unsigned STAT_TIMEOUT  = 0;
    localparam int unsigned STAT_OVERFLOW = 1;
    localparam int unsigned STAT_PENDING  = 2;
    localparam int unsigned STAT_UNREACH  = 3;
    localparam int unsigned STAT_W        = 4;
endpackage

// File: rtl/rrb_ctrl.sv
// Module: rrb_ctrl
// Transaction sequencer. It accepts a read command only when idle, offers
// the request until the link takes it, and then waits for a reply of a
// known type.
// Assumes: the command is a one-cycle pulse; the reply is a one-cycle strobe.
module rrb_ctrl
    import rrb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_read,
    input  logic       chan_unreachable,
    input  logic       req_ready,
    input  logic       rep_valid,
    input  logic [1:0] rep_type,
    output logic       accept,
    output logic       reject,
    output logic       done_event,
    output logic       done_noevent,
    output logic       req_valid,
    output logic       pending
);
    rrb_state_e state_q, state_d;

    // Decode the one-cycle events that the other blocks act on.
    always_comb begin
        accept       = (state_q == ST_IDLE) && cmd_read && !chan_unreachable;
        reject       = (state_q == ST_IDLE) && cmd_read &&  chan_unreachable;
        done_event   = (state_q == ST_WAIT) && rep_valid && (rep_type == REP_EVENT);
        done_noevent = (state_q == ST_WAIT) && rep_valid && (rep_type == REP_NOEVENT);
        req_valid    = (state_q == ST_SEND);
        pending      = (state_q != ST_IDLE);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept)                      state_d = ST_SEND;
            ST_SEND: if (req_ready)                   state_d = ST_WAIT;
            ST_WAIT: if (done_event || done_noevent)  state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rrb_cmd_capture.sv
// Module: rrb_cmd_capture
// Holds the channel and timeout of the accepted command. These values drive
// the request fields for the whole transaction.
// Assumes: accept is high only when no transaction is open.
module rrb_cmd_capture #(
    parameter int CHAN_W = 24,
    parameter int TS_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic [TS_W-1:0]   cmd_timeout,
    output logic [CHAN_W-1:0] req_chan,
    output logic [TS_W-1:0]   req_timeout
);
    // Latch the request fields on an accepted command only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_chan    <= '0;
            req_timeout <= '0;
        end else if (accept) begin
            req_chan    <= cmd_chan;
            req_timeout <= cmd_timeout;
        end
    end
endmodule

// File: rtl/rrb_result.sv
// Module: rrb_result
// Error flags and result registers, plus the status word assembly. A new
// command, accepted or rejected as unreachable, clears everything. A reply
// loads the outcome.
// Assumes: at most one of accept/reject/done_* is high in a cycle.
module rrb_result
    import rrb_pkg::*;
#(
    parameter int TS_W   = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              reject,
    input  logic              done_event,
    input  logic              done_noevent,
    input  logic              pending,
    input  logic              rep_overflow,
    input  logic [TS_W-1:0]   rep_timestamp,
    input  logic [DATA_W-1:0] rep_data,
    output logic [STAT_W-1:0] in_status,
    output logic [TS_W-1:0]   in_timestamp,
    output logic [DATA_W-1:0] in_data
);
    logic timeout_q, overflow_q, unreach_q;

    // Update error flags and results from commands and replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q    <= 1'b0;
            overflow_q   <= 1'b0;
            unreach_q    <= 1'b0;
            in_timestamp <= '0;
            in_data      <= '0;
        end else if (accept || reject) begin
            timeout_q    <= 1'b0;
            overflow_q   <= 1'b0;
            unreach_q    <= reject;
            in_timestamp <= '0;
            in_data      <= '0;
        end else if (done_event) begin
            in_timestamp <= rep_timestamp;
            in_data      <= rep_data;
        end else if (done_noevent) begin
            timeout_q    <= !rep_overflow;
            overflow_q   <= rep_overflow;
        end
    end

    // Assemble the status word from flags and the sequencer's pending state.
    always_comb begin
        in_status               = '0;
        in_status[STAT_TIMEOUT] = timeout_q;
        in_status[STAT_OVERFLOW]= overflow_q;
        in_status[STAT_PENDING] = pending;
        in_status[STAT_UNREACH] = unreach_q;
    end
endmodule

// File: rtl/remote_read_bridge.sv
// Module: remote_read_bridge
// Top level. It turns a local input-read command into one read request on
// the link, waits for the reply, and reports event, timeout, overflow or
// unreachable through the status word and result outputs.
// Assumes: chan_unreachable is a valid lookup of cmd_chan in the same cycle.
module remote_read_bridge
    import rrb_pkg::*;
#(
    parameter int CHAN_W = 24,
    parameter int TS_W   = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_read,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic [TS_W-1:0]   cmd_timeout,
    input  logic              chan_unreachable,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [CHAN_W-1:0] req_chan,
    output logic [TS_W-1:0]   req_timeout,
    input  logic              rep_valid,
    input  logic [1:0]        rep_type,
    input  logic              rep_overflow,
    input  logic [TS_W-1:0]   rep_timestamp,
    input  logic [DATA_W-1:0] rep_data,
    output logic [STAT_W-1:0] in_status,
    output logic [TS_W-1:0]   in_timestamp,
    output logic [DATA_W-1:0] in_data
);
    logic accept, reject, done_event, done_noevent, pending;

    rrb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read),
        .chan_unreachable(chan_unreachable), .req_ready(req_ready),
        .rep_valid(rep_valid), .rep_type(rep_type),
        .accept(accept), .reject(reject), .done_event(done_event),
        .done_noevent(done_noevent), .req_valid(req_valid), .pending(pending)
    );

    rrb_cmd_capture #(.CHAN_W(CHAN_W), .TS_W(TS_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .cmd_chan(cmd_chan), .cmd_timeout(cmd_timeout),
        .req_chan(req_chan), .req_timeout(req_timeout)
    );

    rrb_result #(.TS_W(TS_W), .DATA_W(DATA_W)) u_result (
        .clk(clk), .rst_n(rst_n), .accept(accept), .reject(reject),
        .done_event(done_event), .done_noevent(done_noevent),
        .pending(pending), .rep_overflow(rep_overflow),
        .rep_timestamp(rep_timestamp), .rep_data(rep_data),
        .in_status(in_status), .in_timestamp(in_timestamp), .in_data(in_data)
    );
endmodule

// File: rtl/rrb_checker.sv
// Module: rrb_checker
// Port-level properties of the bridge, bound to the top module.
module rrb_checker #(
    parameter int CHAN_W = 24,
    parameter int TS_W   = 64,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_read,
    input logic              chan_unreachable,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CHAN_W-1:0] req_chan,
    input logic [TS_W-1:0]   req_timeout,
    input logic              rep_valid,
    input logic [1:0]        rep_type,
    input logic              rep_overflow,
    input logic [TS_W-1:0]   rep_timestamp,
    input logic [DATA_W-1:0] rep_data,
    input logic [3:0]        in_status,
    input logic [TS_W-1:0]   in_timestamp,
    input logic [DATA_W-1:0] in_data
);
    logic waiting;
    assign waiting = in_status[2] && !req_valid;

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && !in_status[2] && !chan_unreachable) |=> (in_status[2] && req_valid));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_chan) && $stable(req_timeout)));

    p_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rep_valid && rep_type == 2'd1) |=>
        (in_status == 4'h0 && in_timestamp == $past(rep_timestamp) && in_data == $past(rep_data)));

    p_noevent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && rep_valid && rep_type == 2'd2) |=>
        (in_status == {2'b00, $past(rep_overflow), !$past(rep_overflow)}));

    p_unreach_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && !in_status[2] && chan_unreachable) |=> (in_status == 4'h8 && !req_valid));

    p_no_req_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_status[2] |-> !req_valid);

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_status));
endmodule

bind remote_read_bridge rrb_checker #(.CHAN_W(CHAN_W), .TS_W(TS_W), .DATA_W(DATA_W)) u_rrb_checker (
    .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .chan_unreachable(chan_unreachable),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_timeout(req_timeout), .rep_valid(rep_valid), .rep_type(rep_type),
    .rep_overflow(rep_overflow), .rep_timestamp(rep_timestamp), .rep_data(rep_data),
    .in_status(in_status), .in_timestamp(in_timestamp), .in_data(in_data)
);

// File: tb/test_remote_read_bridge.sv
`timescale 1ns/1ps
module test_remote_read_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_read = 1'b0;
    logic [23:0] cmd_chan = '0;
    logic [63:0] cmd_timeout = '0;
    logic        chan_unreachable = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [23:0] req_chan;
    logic [63:0] req_timeout;
    logic        rep_valid = 1'b0;
    logic [1:0]  rep_type = '0;
    logic        rep_overflow = 1'b0;
    logic [63:0] rep_timestamp = '0;
    logic [31:0] rep_data = '0;
    logic [3:0]  in_status;
    logic [63:0] in_timestamp;
    logic [31:0] in_data;

    int checks = 0;
    int errors = 0;
    int handshakes = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    remote_read_bridge i_remote_read_bridge (.*);

    // Count request handshakes at each rising edge.
    always @(posedge clk) if (rst_n && req_valid && req_ready) handshakes++;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected status for an outcome: 0 event, 1 timeout, 2 overflow, 3 unreachable.
    function automatic logic [3:0] exp_status(int kind);
        case (kind)
            0: return 4'h0;
            1: return 4'h1;
            2: return 4'h2;
            default: return 4'h8;
        endcase
    endfunction

    // One full read transaction with optional disturbances.
    task automatic do_read(int kind, logic [23:0] ch, logic [63:0] to,
                           logic [63:0] ts, logic [31:0] dt, int ready_delay,
                           bit stray, bit extra_cmd, bit bad_type);
        int hs0 = handshakes;
        @(negedge clk);
        cmd_read = 1'b1; cmd_chan = ch; cmd_timeout = to;
        chan_unreachable = (kind == 3);
        @(negedge clk);
        cmd_read = 1'b0; chan_unreachable = 1'b0;
        cmd_chan = ~ch; cmd_timeout = ~to;
        if (kind == 3) begin
            check("R7 status", in_status, 64'h8);
            check("R7 no request", req_valid, 0);
            check("R7 results cleared", in_timestamp, 0);
            repeat (2) @(negedge clk);
            check("R7 no handshake", handshakes - hs0, 0);
            return;
        end
        check("R2 pending", in_status, 64'h4);
        check("R2 req_valid", req_valid, 1);
        check("R2 req_chan", req_chan, ch);
        check("R2 req_timeout", req_timeout, to);
        check("R2 results cleared", {in_data, 32'h0} | in_timestamp, 0);
        if (stray) begin
            rep_valid = 1'b1; rep_type = 2'd1; rep_timestamp = 64'hdead; rep_data = 32'hbeef;
            @(negedge clk);
            rep_valid = 1'b0;
            check("R9 early reply ignored", in_status, 64'h4);
            check("R9 early reply no result", in_timestamp, 0);
        end
        for (int i = 0; i < ready_delay; i++) begin
            @(negedge clk);
            check("R3 held", {req_valid, req_chan}, {1'b1, ch});
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        check("R3 one handshake", handshakes - hs0, 1);
        check("R3 request dropped", req_valid, 0);
        if (extra_cmd) begin
            cmd_read = 1'b1; cmd_chan = ch + 24'd1; cmd_timeout = to + 1;
            @(negedge clk);
            cmd_read = 1'b0;
            repeat (2) @(negedge clk);
            check("R8 still pending", in_status, 64'h4);
            check("R8 no new request", req_valid, 0);
            check("R8 fields kept", req_chan, ch);
        end
        if (bad_type) begin
            rep_valid = 1'b1; rep_type = 2'd3; rep_timestamp = ts + 5;
            @(negedge clk);
            rep_valid = 1'b0;
            check("R9 bad type ignored", in_status, 64'h4);
        end
        rep_valid = 1'b1;
        rep_type = (kind == 0) ? 2'd1 : 2'd2;
        rep_overflow = (kind == 2);
        rep_timestamp = ts; rep_data = dt;
        @(negedge clk);
        rep_valid = 1'b0; rep_overflow = 1'b0; rep_timestamp = '1; rep_data = '1;
        check(kind == 0 ? "R4 status" : (kind == 1 ? "R5 status" : "R6 status"),
              in_status, exp_status(kind));
        check("R4 timestamp", in_timestamp, kind == 0 ? ts : 64'h0);
        check("R4 data", in_data, kind == 0 ? {32'h0, dt} : 64'h0);
        repeat (3) @(negedge clk);
        check("R10 status held", in_status, exp_status(kind));
        check("R10 timestamp held", in_timestamp, kind == 0 ? ts : 64'h0);
        check("R3 total handshakes", handshakes - hs0, 1);
    endtask

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        check("R1 status", in_status, 0);
        check("R1 req_valid", req_valid, 0);
        check("R1 results", in_timestamp | {32'h0, in_data}, 0);
        rst_n = 1'b1;
        do_read(0, 24'd19, 64'd145, 64'd333, 32'd23, 0, 0, 0, 0);
        do_read(0, 24'd20, 64'd146, 64'd334, 32'd24, 2, 1, 1, 0);
        do_read(1, 24'd10, 64'd34, 64'd0, 32'd0, 1, 0, 0, 1);
        do_read(2, 24'd1, 64'd20, 64'd0, 32'd0, 0, 0, 1, 0);
        do_read(3, 24'd5, 64'd9, 64'd0, 32'd0, 0, 0, 0, 0);
        do_read(0, 24'hffffff, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_fffe, 32'hffffffff, 3, 0, 0, 0);
        for (int n = 0; n < 60; n++) begin
            do_read(int'($urandom_range(0, 3)), 24'($urandom), {$urandom, $urandom},
                    {$urandom, $urandom}, $urandom, int'($urandom_range(0, 4)),
                    bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                    bit'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule